// File: doc/BRIEF.md
# Countdown Timer Bank with Guarded Watchdog

This block holds four countdown timers and one watchdog. All of them are reached through a plain word-addressed register port, which has an address, a write strobe, write data and a combinational read-data return. A timer takes its start value from the control word that enables it. It then counts down once per clock, and at zero it halts and raises a sticky status flag. Each timer flag can be routed to the level interrupt through its own mask bit. The watchdog flag always reaches the interrupt.

The watchdog cannot be started or halted by a single stray store. Starting takes one ordered pair of key words written to its control word. Halting and reloading takes a different ordered pair. When the watchdog counts out, it reloads its default count and halts. It then holds a reset-request output high for a programmable number of clocks. The block also keeps a small set of sticky reset-cause flags and turns a software command into a one-clock reset request.

Top module: `tmr_wdog`

## Requirements
- R1: After reset the following read as zero: every timer control and count word, the mask (0x20) and the status (0x24). The watchdog default (0x28) and the watchdog count (0x2C) read WD_DEF_INIT, and the pulse length (0x30) reads PULSE_INIT. The cause word (0x38) reads 0x8000_0000. irq, wd_rst_req and sw_rst_req are low.
- R2: A write to timer control word i (byte offset 4*i) with bit 31 set loads bits 29:0 into the count. From the next clock the count word at 0x10+4*i drops by one per clock, and it reads in bits 29:0. While the timer runs, the control word reads back with bit 31 set.
- R3: A timer loaded with N reaches zero on the Nth clock edge after the load edge. On that edge its status bit i in 0x24 is set. The timer then halts at zero and its control bit 31 reads 0.
- R4: A control write with bit 31 clear halts the timer and keeps its count. If bit 30 is also set, the count is cleared to zero. Neither write sets the status bit.
- R5: Status bits in 0x24 stay set until a 1 is written to them. Writing 0 to a bit leaves it as it is.
- R6: irq is high when any timer status bit i in 0x24 is set together with mask bit i in 0x20 (bits 3:0). irq is also high whenever watchdog status bit 4 is set, whatever the mask. Mask bits above 3 read as zero.
- R7: Writing 0xFF00 and then 0x00FF to 0x2C starts the watchdog. Reading 0x2C returns its count, which drops by one per clock after the start edge.
- R8: Writing 0xEE00 and then 0x00EE to 0x2C halts the watchdog and reloads its count from 0x28.
- R9: If any bus write other than the expected second key comes between the two halves of a sequence, the half-sequence is dropped and the second key then has no effect.
- R10: When a running watchdog count reaches zero, the following happen on that edge: status bit 4 is set, the count reloads from 0x28 and the watchdog halts. wd_rst_req is then high for exactly L clocks, where L is the value in 0x30, and a value of 0 acts as 1.
- R11: Writing 0x34 with bit 0 set gives a one-clock pulse on sw_rst_req and sets bit 29 of 0x38. Writing bit 0 as 0 does nothing.
- R12: The cause flags in 0x38 are bit 31 power-on (set by reset), bit 30 hardware (set by hw_rst_evt or by a watchdog expiry), bit 29 software and bit 28 PCIe (set by pcie_rst_evt). Each flag is cleared by writing a 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_rst_evt | input | 1 | One-clock report of a hardware reset event |
| pcie_rst_evt | input | 1 | One-clock report of a PCIe-initiated reset event |
| irq | output | 1 | Level interrupt |
| wd_rst_req | output | 1 | Watchdog reset-request pulse |
| sw_rst_req | output | 1 | Software reset-request pulse |

## Verification
A wrong count or a wrong run flag in any channel shows at once in its count word, which is read every few clocks, and it moves the cycle on which the status bit and irq appear. A watchdog sequence state that is wrong by one step would either start the watchdog after a broken sequence or fail to start it after a correct one. In both cases the count word shows the error within two clocks, because it either moves or stays put. An expiry counted from the wrong cycle, or a pulse counter that is wrong by one, changes the edge on which wd_rst_req rises or falls, and both edges are sampled exactly.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Register word indexes (byte offset / 4)
  localparam int W_CTL0  = 0;
  localparam int W_CNT0  = 4;
  localparam int W_MASK  = 8;
  localparam int W_STS   = 9;
  localparam int W_WDDEF = 10;
  localparam int W_WDCTL = 11;
  localparam int W_PLEN  = 12;
  localparam int W_SWRST = 13;
  localparam int W_CAUSE = 14;

  // Watchdog key words
  localparam logic [31:0] KEY_GO1   = 32'h0000_FF00;
  localparam logic [31:0] KEY_GO2   = 32'h0000_00FF;
  localparam logic [31:0] KEY_HALT1 = 32'h0000_EE00;
  localparam logic [31:0] KEY_HALT2 = 32'h0000_00EE;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_GO,
    SEQ_HALT
  } tw_seq_e;
endpackage

// File: rtl/tw_chan.sv
module tw_chan #(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic             halt_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             exp_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             exp_c;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    exp_c = 1'b0;
    if (ld_i) begin
      cnt_d = ld_val_i;
      run_d = 1'b1;
    end else if (halt_i) begin
      run_d = 1'b0;
      if (clr_i) cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = '0;
        run_d = 1'b0;
        exp_c = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign exp_o = exp_c;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ld_i && !halt_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2

  AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_c && !ld_i) |=> (!run_q && cnt_q == '0)); // R3

  AST_HALT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !ld_i && !clr_i) |=> (!run_q && $stable(cnt_q))); // R4
endmodule

// File: rtl/tw_wdog.sv
module tw_wdog
  import tw_pkg::*;
#(
  parameter int          WD_W    = 32,
  parameter int          PULSE_W = 16,
  parameter logic [WD_W-1:0] CNT_INIT = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_wr_i,
  input  logic               ctl_wr_i,
  input  logic [31:0]        wdata_i,
  input  logic [WD_W-1:0]    def_i,
  input  logic [PULSE_W-1:0] plen_i,
  output logic [WD_W-1:0]    cnt_o,
  output logic               exp_o,
  output logic               rst_req_o
);
  tw_seq_e            seq_q, seq_d;
  logic [WD_W-1:0]    cnt_q, cnt_d;
  logic               run_q, run_d;
  logic [PULSE_W-1:0] pcnt_q, pcnt_d;
  logic               go_c, halt_c, exp_c;

  // Key sequence tracker
  always_comb begin
    seq_d  = seq_q;
    go_c   = 1'b0;
    halt_c = 1'b0;
    if (any_wr_i) begin
      seq_d = SEQ_IDLE;
      if (ctl_wr_i) begin
        if (seq_q == SEQ_GO && wdata_i == KEY_GO2)
          go_c = 1'b1;
        else if (seq_q == SEQ_HALT && wdata_i == KEY_HALT2)
          halt_c = 1'b1;
        else if (wdata_i == KEY_GO1)
          seq_d = SEQ_GO;
        else if (wdata_i == KEY_HALT1)
          seq_d = SEQ_HALT;
      end
    end
  end

  // Counter and pulse stretcher
  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    exp_c  = 1'b0;
    pcnt_d = pcnt_q;
    if (halt_c) begin
      cnt_d = def_i;
      run_d = 1'b0;
    end else if (go_c) begin
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q <= WD_W'(1)) begin
        cnt_d = def_i;
        run_d = 1'b0;
        exp_c = 1'b1;
      end else begin
        cnt_d = cnt_q - WD_W'(1);
      end
    end
    if (exp_c)
      pcnt_d = (plen_i == '0) ? PULSE_W'(1) : plen_i;
    else if (pcnt_q != '0)
      pcnt_d = pcnt_q - PULSE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SEQ_IDLE;
      cnt_q  <= CNT_INIT;
      run_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      seq_q  <= seq_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign exp_o     = exp_c;
  assign rst_req_o = (pcnt_q != '0);

  AST_START_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(seq_q == SEQ_GO && ctl_wr_i && wdata_i == KEY_GO2)); // R7

  AST_HALT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    halt_c |=> (!run_q && cnt_q == $past(def_i))); // R8

  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    exp_c |=> (!run_q && cnt_q == $past(def_i) && rst_req_o)); // R10

  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(exp_c)); // R10
endmodule

// File: rtl/tw_cause.sv
module tw_cause (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_set_i,
  input  logic       sw_set_i,
  input  logic       pcie_set_i,
  input  logic       clr_wr_i,
  input  logic [3:0] clr_mask_i,
  output logic [3:0] flags_o
);
  // flags: [3] power-on, [2] hardware, [1] software, [0] PCIe
  logic [3:0] flags_q, flags_d;
  logic [3:0] clr_c;

  always_comb begin
    clr_c   = clr_wr_i ? clr_mask_i : 4'b0000;
    flags_d = (flags_q & ~clr_c) | {1'b0, hw_set_i, sw_set_i, pcie_set_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= 4'b1000;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R12
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
  import tw_pkg::*;
#(
  parameter int N_TMR   = 4,
  parameter int CNT_W   = 30,
  parameter int WD_W    = 32,
  parameter int PULSE_W = 16,
  parameter int ADDR_W  = 6,
  parameter logic [WD_W-1:0]    WD_DEF_INIT = 32'h0000_0100,
  parameter logic [PULSE_W-1:0] PULSE_INIT  = 16'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_rst_evt,
  input  logic              pcie_rst_evt,
  output logic              irq,
  output logic              wd_rst_req,
  output logic              sw_rst_req
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int STS_W  = N_TMR + 1;

  logic [WORD_W-1:0] word;
  logic              unused_addr_lsb;
  assign word            = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  logic wr_mask, wr_sts, wr_def, wr_wdctl, wr_plen, wr_swrst, wr_cause;
  assign wr_mask  = bus_we && (word == WORD_W'(W_MASK));
  assign wr_sts   = bus_we && (word == WORD_W'(W_STS));
  assign wr_def   = bus_we && (word == WORD_W'(W_WDDEF));
  assign wr_wdctl = bus_we && (word == WORD_W'(W_WDCTL));
  assign wr_plen  = bus_we && (word == WORD_W'(W_PLEN));
  assign wr_swrst = bus_we && (word == WORD_W'(W_SWRST));
  assign wr_cause = bus_we && (word == WORD_W'(W_CAUSE));

  // Timer channels
  logic [CNT_W-1:0] ldv_q [N_TMR];
  logic [CNT_W-1:0] t_cnt [N_TMR];
  logic [N_TMR-1:0] t_run, t_exp;

  for (genvar i = 0; i < N_TMR; i++) begin : g_chan
    logic ctl_wr;
    assign ctl_wr = bus_we && (word == WORD_W'(W_CTL0 + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ldv_q[i] <= '0;
      else if (ctl_wr) ldv_q[i] <= bus_wdata[CNT_W-1:0];
    end

    tw_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_i     (ctl_wr && bus_wdata[31]),
      .halt_i   (ctl_wr && !bus_wdata[31]),
      .clr_i    (bus_wdata[30]),
      .ld_val_i (bus_wdata[CNT_W-1:0]),
      .cnt_o    (t_cnt[i]),
      .run_o    (t_run[i]),
      .exp_o    (t_exp[i])
    );
  end

  // Watchdog
  logic [WD_W-1:0]    def_q;
  logic [PULSE_W-1:0] plen_q;
  logic [WD_W-1:0]    wd_cnt;
  logic               wd_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_q  <= WD_DEF_INIT;
      plen_q <= PULSE_INIT;
    end else begin
      if (wr_def)  def_q  <= bus_wdata[WD_W-1:0];
      if (wr_plen) plen_q <= bus_wdata[PULSE_W-1:0];
    end
  end

  tw_wdog #(.WD_W(WD_W), .PULSE_W(PULSE_W), .CNT_INIT(WD_DEF_INIT)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_wr_i  (bus_we),
    .ctl_wr_i  (wr_wdctl),
    .wdata_i   (bus_wdata),
    .def_i     (def_q),
    .plen_i    (plen_q),
    .cnt_o     (wd_cnt),
    .exp_o     (wd_exp),
    .rst_req_o (wd_rst_req)
  );

  // Mask, status, software reset
  logic [N_TMR-1:0] mask_q, mask_d;
  logic [STS_W-1:0] sts_q, sts_d;
  logic             swreq_d, swreq_q;

  always_comb begin
    mask_d  = wr_mask ? bus_wdata[N_TMR-1:0] : mask_q;
    sts_d   = (sts_q & ~(wr_sts ? bus_wdata[STS_W-1:0] : STS_W'(0))) | {wd_exp, t_exp};
    swreq_d = wr_swrst && bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      sts_q   <= '0;
      swreq_q <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      sts_q   <= sts_d;
      swreq_q <= swreq_d;
    end
  end

  assign sw_rst_req = swreq_q;
  assign irq        = (|(sts_q[N_TMR-1:0] & mask_q)) | sts_q[N_TMR];

  // Reset cause
  logic [3:0] cause;
  tw_cause u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_set_i   (hw_rst_evt || wd_exp),
    .sw_set_i   (swreq_d),
    .pcie_set_i (pcie_rst_evt),
    .clr_wr_i   (wr_cause),
    .clr_mask_i (bus_wdata[31:28]),
    .flags_o    (cause)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (word == WORD_W'(W_CTL0 + i)) begin
        bus_rdata[31]        = t_run[i];
        bus_rdata[CNT_W-1:0] = ldv_q[i];
      end
      if (word == WORD_W'(W_CNT0 + i))
        bus_rdata[CNT_W-1:0] = t_cnt[i];
    end
    case (word)
      WORD_W'(W_MASK):  bus_rdata[N_TMR-1:0]   = mask_q;
      WORD_W'(W_STS):   bus_rdata[STS_W-1:0]   = sts_q;
      WORD_W'(W_WDDEF): bus_rdata[WD_W-1:0]    = def_q;
      WORD_W'(W_WDCTL): bus_rdata[WD_W-1:0]    = wd_cnt;
      WORD_W'(W_PLEN):  bus_rdata[PULSE_W-1:0] = plen_q;
      WORD_W'(W_CAUSE): bus_rdata[31:28]       = cause;
      default: ;
    endcase
  end

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> (($past(sts_q) & ~sts_q) == '0)); // R5

  AST_WD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wd_exp) |-> irq); // R6

  AST_SW_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req |-> $past(wr_swrst && bus_wdata[0])); // R11
endmodule

// File: tb/sim_tmr_wdog.sv
module sim_tmr_wdog;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        hw_rst_evt, pcie_rst_evt;
  logic        irq, wd_rst_req, sw_rst_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_wdog u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .hw_rst_evt   (hw_rst_evt),
    .pcie_rst_evt (pcie_rst_evt),
    .irq          (irq),
    .wd_rst_req   (wd_rst_req),
    .sw_rst_req   (sw_rst_req)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  // R1 reset reads, then R6 mask width and watchdog register read-back
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h00, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h04, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h08, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h0C, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h10, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h14, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h18, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h1C, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h20, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h24, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h28, 32'h0, 32'h0000_0100},
    '{1'b0, 6'h2C, 32'h0, 32'h0000_0100},
    '{1'b0, 6'h30, 32'h0, 32'h0000_0004},
    '{1'b0, 6'h38, 32'h0, 32'h8000_0000},
    '{1'b1, 6'h20, 32'h0000_000F, 32'h0},
    '{1'b0, 6'h20, 32'h0, 32'h0000_000F},
    '{1'b1, 6'h20, 32'hFFFF_FFF0, 32'h0},
    '{1'b0, 6'h20, 32'h0, 32'h0000_0000},
    '{1'b0, 6'h2C, 32'h0, 32'h0000_0100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    hw_rst_evt = 1'b0; pcie_rst_evt = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 output pins after reset
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 wd_rst_req", {31'b0, wd_rst_req}, 32'h0);
    chk("R1 sw_rst_req", {31'b0, sw_rst_req}, 32'h0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) wr(VEC[k].a, VEC[k].d);
      else rdchk($sformatf("R1 table %0d", k), VEC[k].a, VEC[k].e);
    end

    // Timer 0: R2 countdown, R3 expiry
    wr(6'h00, 32'h8000_0005);
    rdchk("R2 t0 load", 6'h10, 32'd5);
    rdchk("R2 t0 run bit", 6'h00, 32'h8000_0005);
    step(2);
    rdchk("R2 t0 count", 6'h10, 32'd3);
    step(2);
    rdchk("R2 t0 count one", 6'h10, 32'd1);
    rdchk("R3 t0 not yet", 6'h24, 32'h0);
    step(1);
    rdchk("R3 t0 zero", 6'h10, 32'd0);
    rdchk("R3 t0 status", 6'h24, 32'h1);
    chk("R6 masked off", {31'b0, irq}, 32'h0);
    step(3);
    rdchk("R3 t0 stays zero", 6'h10, 32'd0);
    rdchk("R3 t0 halted", 6'h00, 32'h0000_0005);
    wr(6'h24, 32'h0);
    rdchk("R5 write zero keeps", 6'h24, 32'h1);
    wr(6'h20, 32'h1);
    chk("R6 mask on", {31'b0, irq}, 32'h1);
    wr(6'h24, 32'h1);
    rdchk("R5 w1c", 6'h24, 32'h0);
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);

    // Timer 1: R4 halt and clear
    wr(6'h04, 32'h8000_0064);
    step(3);
    rdchk("R2 t1 count", 6'h14, 32'd97);
    wr(6'h04, 32'h0000_0000);
    rdchk("R4 t1 halt", 6'h14, 32'd97);
    step(2);
    rdchk("R4 t1 held", 6'h14, 32'd97);
    wr(6'h04, 32'h4000_0000);
    rdchk("R4 t1 clear", 6'h14, 32'd0);
    rdchk("R4 no status", 6'h24, 32'h0);

    // Timer 3: load of one, mask routing
    wr(6'h0C, 32'h8000_0001);
    rdchk("R2 t3 load", 6'h1C, 32'd1);
    rdchk("R3 t3 not yet", 6'h24, 32'h0);
    step(1);
    rdchk("R3 t3 status", 6'h24, 32'h8);
    chk("R6 other mask", {31'b0, irq}, 32'h0);
    wr(6'h20, 32'h8);
    chk("R6 t3 mask", {31'b0, irq}, 32'h1);
    wr(6'h24, 32'h8);
    chk("R6 t3 cleared", {31'b0, irq}, 32'h0);
    wr(6'h20, 32'h0);

    // Watchdog: R8 reload, R7 start
    wr(6'h28, 32'd20);
    wr(6'h2C, 32'h0000_EE00);
    wr(6'h2C, 32'h0000_00EE);
    rdchk("R8 reload", 6'h2C, 32'd20);
    wr(6'h2C, 32'h0000_FF00);
    wr(6'h2C, 32'h0000_00FF);
    rdchk("R7 start edge", 6'h2C, 32'd20);
    step(5);
    rdchk("R7 counting", 6'h2C, 32'd15);
    wr(6'h2C, 32'h0000_EE00);
    wr(6'h2C, 32'h0000_00EE);
    rdchk("R8 halt reload", 6'h2C, 32'd20);
    step(3);
    rdchk("R8 halted", 6'h2C, 32'd20);

    // R9 broken sequences
    wr(6'h2C, 32'h0000_FF00);
    wr(6'h2C, 32'h0000_1234);
    wr(6'h2C, 32'h0000_00FF);
    step(2);
    rdchk("R9 wrong key", 6'h2C, 32'd20);
    wr(6'h2C, 32'h0000_FF00);
    wr(6'h20, 32'h0);
    wr(6'h2C, 32'h0000_00FF);
    step(2);
    rdchk("R9 other write", 6'h2C, 32'd20);

    // R10 expiry and pulse length 3
    wr(6'h30, 32'd3);
    wr(6'h28, 32'd6);
    wr(6'h2C, 32'h0000_EE00);
    wr(6'h2C, 32'h0000_00EE);
    wr(6'h2C, 32'h0000_FF00);
    wr(6'h2C, 32'h0000_00FF);
    step(5);
    rdchk("R10 count one", 6'h2C, 32'd1);
    chk("R10 no pulse yet", {31'b0, wd_rst_req}, 32'h0);
    rdchk("R10 no status yet", 6'h24, 32'h0);
    step(1);
    chk("R10 pulse rise", {31'b0, wd_rst_req}, 32'h1);
    rdchk("R10 status", 6'h24, 32'h10);
    chk("R6 wd irq unmasked", {31'b0, irq}, 32'h1);
    rdchk("R10 reload", 6'h2C, 32'd6);
    rdchk("R12 hw flag", 6'h38, 32'hC000_0000);
    step(2);
    chk("R10 pulse held", {31'b0, wd_rst_req}, 32'h1);
    step(1);
    chk("R10 pulse fall", {31'b0, wd_rst_req}, 32'h0);
    rdchk("R10 halted", 6'h2C, 32'd6);
    wr(6'h24, 32'h10);
    chk("R5 wd cleared", {31'b0, irq}, 32'h0);

    // R10 pulse length zero acts as one
    wr(6'h30, 32'd0);
    wr(6'h28, 32'd2);
    wr(6'h2C, 32'h0000_EE00);
    wr(6'h2C, 32'h0000_00EE);
    wr(6'h2C, 32'h0000_FF00);
    wr(6'h2C, 32'h0000_00FF);
    step(1);
    chk("R10 len0 before", {31'b0, wd_rst_req}, 32'h0);
    step(1);
    chk("R10 len0 pulse", {31'b0, wd_rst_req}, 32'h1);
    step(1);
    chk("R10 len0 end", {31'b0, wd_rst_req}, 32'h0);

    // R11 software reset
    wr(6'h34, 32'h0);
    chk("R11 bit0 zero", {31'b0, sw_rst_req}, 32'h0);
    wr(6'h34, 32'h1);
    chk("R11 pulse", {31'b0, sw_rst_req}, 32'h1);
    step(1);
    chk("R11 one clock", {31'b0, sw_rst_req}, 32'h0);
    rdchk("R11 sw flag", 6'h38, 32'hE000_0000);

    // R12 cause flags
    wr(6'h38, 32'hF000_0000);
    rdchk("R12 w1c", 6'h38, 32'h0);
    pcie_rst_evt = 1'b1;
    step(1);
    pcie_rst_evt = 1'b0;
    rdchk("R12 pcie", 6'h38, 32'h1000_0000);
    hw_rst_evt = 1'b1;
    step(1);
    hw_rst_evt = 1'b0;
    rdchk("R12 hw evt", 6'h38, 32'h5000_0000);
    wr(6'h38, 32'h1000_0000);
    rdchk("R12 partial clear", 6'h38, 32'h4000_0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule